// File: doc/BRIEF.md
# Interrupt Flag and IRQ Controller

This block latches six interrupt event pulses into flag bits and combines them with per-source enable bits to drive one active-low interrupt request. Three of the sources form the main group, whose flags sit in a status register that clears itself when read. The other three form an auxiliary group, whose flags stay set until software writes a zero to their bit positions.

Software uses a single-cycle register port: a read strobe or write strobe, a 2-bit address and an 8-bit write word. Read data appears registered in the cycle after the strobe and holds until the next read. The port has no back-pressure and every strobe is accepted in its cycle. Events that arrive while the main status register is being read are parked in a pending register and merged once the read is over, so no event is lost. A flag is set by its event even when its enable is off, so software can poll the flags with the request line disabled.

Register map: address 0 is the main status register and is read-only. Its bit 7 is the summary bit, bits 6:4 are the main flags, and bits 3:0 read as zero. Address 1 holds the main enables in bits 6:4. Address 2 holds the auxiliary flags in bits 2:0. Address 3 holds the auxiliary enables in bits 2:0. The event input bit i of each group maps to the flag and enable with the same index.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all flags, pending events and enables are 0, `irq_n` is 1 and `rd_data` is 0.
- R2: An event pulse on `ev_main[i]` sets main flag i whether or not its enable is set. The flag reads as bit 4+i of address 0.
- R3: A read strobe loads `rd_data` at the clock edge ending the strobe cycle. Address 0 returns {summary, main flags[2:0], 4'b0000}, addresses 1 and 3 return the enable registers, and address 2 returns {5'b0, auxiliary flags}. `rd_data` holds that value until the next read strobe.
- R4: A read of address 0 clears every main flag at the same edge that captures the snapshot.
- R5: A main event that arrives in the cycle of an address-0 read is absent from that snapshot. It is set in the flag at the end of the first following cycle that is not an address-0 read.
- R6: One read of address 0 can return any combination of the three main flags set together.
- R7: Reads never change the auxiliary flags. A write to address 2 clears auxiliary flag i when `wdata[i]` is 0 and leaves it unchanged when `wdata[i]` is 1.
- R8: If an auxiliary event arrives in the same cycle as a write that clears its bit, the flag ends up set.
- R9: `irq_n` is 0 in the cycle after any flag and its enable are both 1. It returns to 1 in the cycle after no flag/enable pair is both 1.
- R10: The summary bit in an address-0 snapshot equals the inverse of `irq_n` during the strobe cycle.
- R11: Writes to address 1 load `wdata[6:4]` as main enables, and writes to address 3 load `wdata[2:0]` as auxiliary enables. Writes to address 0 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | One-cycle read strobe |
| wr_stb | input | 1 | One-cycle write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ev_main | input | 3 | Event pulses for the clear-on-read group |
| ev_aux | input | 3 | Event pulses for the write-zero-clear group |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Every result is due exactly one clock edge after the cycle that causes it. Flags, `irq_n` and `rd_data` all change at the edge that ends the event, strobe or write cycle. A parked main event needs one more edge, the one that ends the next non-read cycle. The bench drives inputs at the falling edge and compares at the next falling edge, so each comparison sees the state after exactly one rising edge. For each cycle it steps a model of the flags, pending bits and enables, and compares `irq_n` every cycle. It compares `rd_data` after every read, and checks that `rd_data` is unchanged after every other cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_MEN  = 2'd1,
    SEL_AFLG = 2'd2,
    SEL_AEN  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irqc_cor_group.sv
module irqc_cor_group #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         rd_clr,
  output logic [N-1:0] flags
);
  logic [N-1:0] pend_q;

  // A read clears the flags and parks new events; any other cycle merges them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags  <= '0;
      pend_q <= '0;
    end else if (rd_clr) begin
      flags  <= '0;
      pend_q <= pend_q | ev;
    end else begin
      flags  <= flags | pend_q | ev;
      pend_q <= '0;
    end
  end
endmodule

// File: rtl/irqc_wz_group.sv
module irqc_wz_group #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev,
  input  logic         wr_hit,
  input  logic [N-1:0] keep,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags[i] <= 1'b0;
      else if (ev[i])       flags[i] <= 1'b1;
      else if (wr_hit && !keep[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_irq_comb.sv
module irqc_irq_comb #(
  parameter int unsigned NM = 3,
  parameter int unsigned NA = 3
) (
  input  logic [NM-1:0] mflags,
  input  logic [NM-1:0] men,
  input  logic [NA-1:0] aflags,
  input  logic [NA-1:0] aen,
  output logic          active
);
  localparam int unsigned NT = NM + NA;
  logic [NT-1:0] hit;

  assign hit    = {mflags & men, aflags & aen};
  assign active = |hit;
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned NMAIN = 3,
  parameter int unsigned NAUX  = 3,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic             wr_stb,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_data,
  input  logic [NMAIN-1:0] ev_main,
  input  logic [NAUX-1:0]  ev_aux,
  output logic             irq_n
);
  localparam int unsigned SUM_BIT = DW - 1;
  localparam int unsigned MHI     = DW - 2;
  localparam int unsigned MLO     = DW - 1 - NMAIN;

  logic [NMAIN-1:0] mflags, men_q;
  logic [NAUX-1:0]  aflags, aen_q;
  logic             active;
  logic             rd_stat, wr_aflg;
  logic [DW-1:0]    rd_mux;
  reg_sel_e         sel;

  assign sel     = reg_sel_e'(addr[1:0]);
  assign rd_stat = rd_stb && (sel == SEL_STAT);
  assign wr_aflg = wr_stb && (sel == SEL_AFLG);

  irqc_cor_group #(.N(NMAIN)) u_main (
    .clk(clk), .rst_n(rst_n), .ev(ev_main), .rd_clr(rd_stat), .flags(mflags)
  );

  irqc_wz_group #(.N(NAUX)) u_aux (
    .clk(clk), .rst_n(rst_n), .ev(ev_aux), .wr_hit(wr_aflg),
    .keep(wdata[NAUX-1:0]), .flags(aflags)
  );

  irqc_irq_comb #(.NM(NMAIN), .NA(NAUX)) u_irq (
    .mflags(mflags), .men(men_q), .aflags(aflags), .aen(aen_q), .active(active)
  );

  assign irq_n = ~active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q <= '0;
      aen_q <= '0;
    end else if (wr_stb) begin
      if (sel == SEL_MEN) men_q <= wdata[MHI:MLO];
      if (sel == SEL_AEN) aen_q <= wdata[NAUX-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_STAT: begin
        rd_mux[SUM_BIT]  = active;
        rd_mux[MHI:MLO]  = mflags;
      end
      SEL_MEN:  rd_mux[MHI:MLO]    = men_q;
      SEL_AFLG: rd_mux[NAUX-1:0]   = aflags;
      SEL_AEN:  rd_mux[NAUX-1:0]   = aen_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (rd_stb) rd_data <= rd_mux;
  end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int unsigned NMAIN = 3,
  parameter int unsigned NAUX  = 3,
  parameter int unsigned DW    = 8,
  parameter int unsigned AW    = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_stb,
  input logic             wr_stb,
  input logic [AW-1:0]    addr,
  input logic [NMAIN-1:0] ev_main,
  input logic [NAUX-1:0]  ev_aux,
  input logic [DW-1:0]    rd_data,
  input logic             irq_n,
  input logic [NMAIN-1:0] mflags,
  input logic [NAUX-1:0]  aflags
);
  logic rd_stat;
  assign rd_stat = rd_stb && (addr == '0);

  // R2
  ev_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_stat && ev_main[0]) |=> mflags[0]);

  // R4
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (mflags == '0));

  // R5
  pending_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && ev_main[0]) ##1 !rd_stat |=> mflags[0]);

  // R7
  aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_stb && addr == 2'd2) && aflags[0]) |=> aflags[0]);

  // R8
  aux_event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_aux[0] |=> aflags[0]);

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));

  // R10
  summary_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> (rd_data[DW-1] == !$past(irq_n)));
endmodule

bind irq_ctrl irq_ctrl_chk #(.NMAIN(NMAIN), .NAUX(NAUX), .DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr),
  .ev_main(ev_main), .ev_aux(ev_aux), .rd_data(rd_data), .irq_n(irq_n),
  .mflags(mflags), .aflags(aflags)
);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd_stb = 1'b0, wr_stb = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rd_data;
  logic [2:0] ev_main = '0, ev_aux = '0;
  logic       irq_n;

  int n_cmp = 0, n_bad = 0;

  // model state
  logic [2:0] m_f = '0, m_p = '0, m_en = '0, a_f = '0, a_en = '0;
  logic [7:0] m_rd = '0;

  always #2.5 clk = ~clk;

  irq_ctrl u_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .ev_main(ev_main), .ev_aux(ev_aux), .irq_n(irq_n)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic m_act();
    return |(m_f & m_en) || |(a_f & a_en);
  endfunction

  // One bus cycle: drive at falling edge, step model, compare at next falling edge.
  task automatic cyc(input logic rd, input logic wr, input logic [1:0] a,
                     input logic [7:0] wd, input logic [2:0] em, input logic [2:0] ea);
    logic rstat;
    rd_stb = rd; wr_stb = wr; addr = a; wdata = wd; ev_main = em; ev_aux = ea;
    rstat = rd && (a == 2'd0);
    if (rd) begin
      case (a)
        2'd0: m_rd = {m_act(), m_f, 4'b0};
        2'd1: m_rd = {1'b0, m_en, 4'b0};
        2'd2: m_rd = {5'b0, a_f};
        default: m_rd = {5'b0, a_en};
      endcase
    end
    if (rstat) begin m_p = m_p | em; m_f = '0; end
    else begin m_f = m_f | m_p | em; m_p = '0; end
    if (wr && a == 2'd2) a_f = a_f & wd[2:0];
    a_f = a_f | ea;
    if (wr && a == 2'd1) m_en = wd[6:4];
    if (wr && a == 2'd3) a_en = wd[2:0];
    @(negedge clk);
    rd_stb = 0; wr_stb = 0; ev_main = '0; ev_aux = '0;
    chk("R9 irq_n", {7'b0, irq_n}, {7'b0, !m_act()});
    chk(rd ? "R3 rd_data" : "R3 rd_data hold", rd_data, m_rd);
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [7:0] exp);
    cyc(1, 0, a, 8'h00, '0, '0);
    chk(tag, rd_data, exp);
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq_n", {7'b0, irq_n}, 8'h01);
    chk("R1 rd_data", rd_data, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    rd_chk("R1 status", 2'd0, 8'h00);
    rd_chk("R1 aux flags", 2'd2, 8'h00);

    // Main group sweep: all enable x event patterns (R2 R4 R6 R9 R10 R11)
    for (int e = 0; e < 8; e++) begin
      for (int p = 0; p < 8; p++) begin
        cyc(0, 1, 2'd1, 8'(e << 4), '0, '0);
        rd_chk("R11 main enable", 2'd1, 8'(e << 4));
        cyc(0, 0, 2'd0, 8'h00, 3'(p), '0);
        chk("R9 irq after event", {7'b0, irq_n}, {7'b0, !((e & p) != 0)});
        rd_chk("R6 R10 snapshot", 2'd0, {((e & p) != 0) ? 1'b1 : 1'b0, 3'(p), 4'b0});
        chk("R4 irq released", {7'b0, irq_n}, 8'h01);
        rd_chk("R4 cleared", 2'd0, 8'h00);
      end
    end

    // Aux group sweep: enable x event x keep-mask (R7 R9)
    for (int e = 0; e < 8; e++) begin
      cyc(0, 1, 2'd3, 8'(e), '0, '0);
      for (int p = 0; p < 8; p++) begin
        for (int m = 0; m < 8; m++) begin
          cyc(0, 0, 2'd0, 8'h00, '0, 3'(p));
          rd_chk("R7 read keeps", 2'd2, 8'(p));
          rd_chk("R7 second read", 2'd2, 8'(p));
          cyc(0, 1, 2'd2, 8'(m), '0, '0);
          chk("R9 aux irq", {7'b0, irq_n}, {7'b0, !((e & p & m) != 0)});
          rd_chk("R7 write-zero clear", 2'd2, 8'(p & m));
          cyc(0, 1, 2'd2, 8'h00, '0, '0);
        end
      end
    end
    cyc(0, 1, 2'd3, 8'h00, '0, '0);

    // R8: event beats a clearing write
    cyc(0, 0, 2'd0, 8'h00, '0, 3'b101);
    cyc(0, 1, 2'd2, 8'h00, '0, 3'b100);
    rd_chk("R8 event wins", 2'd2, 8'h04);
    cyc(0, 1, 2'd2, 8'h00, '0, '0);

    // R5: event during status read is deferred
    cyc(0, 1, 2'd1, 8'h70, '0, '0);
    cyc(0, 0, 2'd0, 8'h00, 3'b001, '0);
    cyc(1, 0, 2'd0, 8'h00, 3'b110, '0);
    chk("R5 snapshot excludes", rd_data, 8'h90);
    chk("R5 irq during park", {7'b0, irq_n}, 8'h01);
    cyc(0, 0, 2'd0, 8'h00, '0, '0);
    chk("R5 merged irq", {7'b0, irq_n}, 8'h00);
    rd_chk("R5 merged flags", 2'd0, 8'hE0);
    // back-to-back reads keep the parked event
    cyc(1, 0, 2'd0, 8'h00, 3'b010, '0);
    rd_chk("R5 still parked", 2'd0, 8'h00);
    cyc(0, 0, 2'd0, 8'h00, '0, '0);
    rd_chk("R5 merged later", 2'd0, 8'hA0);

    // R11: write to status ignored
    cyc(0, 0, 2'd0, 8'h00, 3'b100, '0);
    cyc(0, 1, 2'd0, 8'h00, '0, '0);
    rd_chk("R11 status write ignored", 2'd0, 8'hC0);
    rd_chk("R11 enable intact", 2'd1, 8'h70);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule